// File: doc/BRIEF.md
# Inter-Core Doorbell Interrupt Unit

This block lets two processor cores raise interrupts on each other. Each core owns an 8-bit vector of pending doorbell bits, and the core's doorbell interrupt line is high while any of its pending bits is set. Each core reaches the block through its own small register port. Through that port it can ring or withdraw doorbells on its peer, and it can set or acknowledge its own pending doorbells. The registers use write-one semantics, so each core touches only the bits it names.

Both ports may write in the same clock cycle, and both may aim at the same pending vector. All set and clear requests that reach one vector in a cycle are merged. A set then overrides a clear of the same bit. Reads return pending state with no wait: the two peer-facing registers show the peer's vector, and the two self-facing registers show the reader's own vector.

Each interrupt line comes from a two-state machine per core. `IRQ_QUIET` moves to `IRQ_RINGING` on the transition RING, taken when the next pending vector has any bit set. `IRQ_RINGING` moves back to `IRQ_QUIET` on the transition ACK_ALL, taken when the next pending vector is all zero. Otherwise each state holds. Because the machine is clocked on the same edge as the pending bits, the interrupt is a registered output that never lags its vector.

Top module: `doorbell_xcore`

## Requirements
- R1: A write to register offset 0 (ring peer) sets every pending bit of the opposite core whose write-data bit is 1, visible after the next rising clock edge.
- R2: A write to offset 1 (withdraw peer) clears every pending bit of the opposite core whose write-data bit is 1.
- R3: A write to offset 2 (set self) sets the writer's own pending bits where the data is 1. A write to offset 3 (acknowledge self) clears them.
- R4: Read data is combinational from the current pending state. Offsets 0 and 1 return the opposite core's vector, and offsets 2 and 3 return the reader's own vector, in bits 7:0 with bits 31:8 zero. A write becomes visible only after the clock edge that applies it.
- R5: A core's interrupt output is high exactly when its pending vector is non-zero after an edge. It falls in the same edge that clears the last pending bit.
- R6: Write-data bits 31:8 have no effect on any pending bit.
- R7: When a set and a clear of the same pending bit arrive in one cycle, from the same core or from different cores, the bit ends up set.
- R8: Data bits written as 0 leave the matching pending bits unchanged. Independent writes from both cores in one cycle all take effect.
- R9: An active-low reset clears all pending bits and drives both interrupt outputs low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c0_we | input | 1 | Core 0 write strobe |
| c0_addr | input | 2 | Core 0 register offset (read and write) |
| c0_wdata | input | 32 | Core 0 write data |
| c0_rdata | output | 32 | Core 0 read data |
| c1_we | input | 1 | Core 1 write strobe |
| c1_addr | input | 2 | Core 1 register offset (read and write) |
| c1_wdata | input | 32 | Core 1 write data |
| c1_rdata | output | 32 | Core 1 read data |
| irq0 | output | 1 | Core 0 doorbell interrupt |
| irq1 | output | 1 | Core 1 doorbell interrupt |

## Verification
A wrong pending bit shows on both read ports in the same cycle. The owner's self-facing read and the peer's peer-facing read both carry it right after the faulty edge. A wrong merge of simultaneous writes, or a swapped peer mapping, appears as the wrong bit set or cleared on the wrong core at the first read after that write. A stuck or lagging interrupt state machine shows as a disagreement between the interrupt line and a read that returns zero or a non-zero vector, within one cycle.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    // Register offsets seen by each core on its own port
    typedef enum logic [1:0] {
        DB_SET_PEER = 2'd0,
        DB_CLR_PEER = 2'd1,
        DB_SET_SELF = 2'd2,
        DB_CLR_SELF = 2'd3
    } db_reg_e;

    // Per-core interrupt line state
    typedef enum logic {
        IRQ_QUIET   = 1'b0,
        IRQ_RINGING = 1'b1
    } irq_state_e;

    localparam int unsigned NUM_CORES = 2;

endpackage

// File: rtl/db_port_decode.sv
module db_port_decode
    import doorbell_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DB_W   = 8
) (
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DB_W-1:0]   set_self,
    output logic [DB_W-1:0]   clr_self,
    output logic [DB_W-1:0]   set_peer,
    output logic [DB_W-1:0]   clr_peer
);

    logic [DB_W-1:0] mask;
    logic            unused_hi;

    assign mask      = wdata[DB_W-1:0];
    assign unused_hi = ^wdata[DATA_W-1:DB_W];

    always_comb begin
        set_self = '0;
        clr_self = '0;
        set_peer = '0;
        clr_peer = '0;
        if (we) begin
            unique case (db_reg_e'(addr))
                DB_SET_PEER: set_peer = mask;
                DB_CLR_PEER: clr_peer = mask;
                DB_SET_SELF: set_self = mask;
                DB_CLR_SELF: clr_self = mask;
            endcase
        end
    end

endmodule

// File: rtl/db_pending_bank.sv
module db_pending_bank #(
    parameter int unsigned DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] set_own,
    input  logic [DB_W-1:0] clr_own,
    input  logic [DB_W-1:0] set_peer,
    input  logic [DB_W-1:0] clr_peer,
    output logic [DB_W-1:0] pend_q,
    output logic [DB_W-1:0] pend_next
);

    logic [DB_W-1:0] set_all;
    logic [DB_W-1:0] clr_all;

    // Requests from both ports are merged; set overrides clear
    always_comb begin
        set_all   = set_own | set_peer;
        clr_all   = clr_own | clr_peer;
        pend_next = (pend_q & ~clr_all) | set_all;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_next;
        end
    end

endmodule

// File: rtl/db_irq_fsm.sv
module db_irq_fsm
    import doorbell_pkg::*;
#(
    parameter int unsigned DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] pend_next,
    output logic            irq
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       any_next;

    assign any_next = |pend_next;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: RING and ACK_ALL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:   if (any_next)  state_d = IRQ_RINGING;
            IRQ_RINGING: if (!any_next) state_d = IRQ_QUIET;
        endcase
    end

    // Output process
    always_comb begin
        irq = (state_q == IRQ_RINGING);
    end

endmodule

// File: rtl/db_read_mux.sv
module db_read_mux
    import doorbell_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DB_W   = 8
) (
    input  logic [1:0]        addr,
    input  logic [DB_W-1:0]   own_pend,
    input  logic [DB_W-1:0]   peer_pend,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - DB_W;

    logic [DB_W-1:0] sel;

    always_comb begin
        unique case (db_reg_e'(addr))
            DB_SET_PEER,
            DB_CLR_PEER: sel = peer_pend;
            DB_SET_SELF,
            DB_CLR_SELF: sel = own_pend;
        endcase
        rdata = {{PAD_W{1'b0}}, sel};
    end

endmodule

// File: rtl/doorbell_xcore.sv
module doorbell_xcore
    import doorbell_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DB_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_we,
    input  logic [1:0]        c0_addr,
    input  logic [DATA_W-1:0] c0_wdata,
    output logic [DATA_W-1:0] c0_rdata,
    input  logic              c1_we,
    input  logic [1:0]        c1_addr,
    input  logic [DATA_W-1:0] c1_wdata,
    output logic [DATA_W-1:0] c1_rdata,
    output logic              irq0,
    output logic              irq1
);

    logic [NUM_CORES-1:0]             we_v;
    logic [NUM_CORES-1:0][1:0]        addr_v;
    logic [NUM_CORES-1:0][DATA_W-1:0] wdata_v;
    logic [NUM_CORES-1:0][DATA_W-1:0] rdata_v;
    logic [NUM_CORES-1:0][DB_W-1:0]   set_self_v;
    logic [NUM_CORES-1:0][DB_W-1:0]   clr_self_v;
    logic [NUM_CORES-1:0][DB_W-1:0]   set_peer_v;
    logic [NUM_CORES-1:0][DB_W-1:0]   clr_peer_v;
    logic [NUM_CORES-1:0][DB_W-1:0]   pend_v;
    logic [NUM_CORES-1:0][DB_W-1:0]   pend_nx_v;
    logic [NUM_CORES-1:0]             irq_v;
    logic [DB_W-1:0]                  pend_c0;
    logic [DB_W-1:0]                  pend_c1;

    assign we_v    = {c1_we, c0_we};
    assign addr_v  = {c1_addr, c0_addr};
    assign wdata_v = {c1_wdata, c0_wdata};

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            localparam int unsigned PEER = NUM_CORES - 1 - c;

            db_port_decode #(.DATA_W(DATA_W), .DB_W(DB_W)) u_dec (
                .we       (we_v[c]),
                .addr     (addr_v[c]),
                .wdata    (wdata_v[c]),
                .set_self (set_self_v[c]),
                .clr_self (clr_self_v[c]),
                .set_peer (set_peer_v[c]),
                .clr_peer (clr_peer_v[c])
            );

            db_pending_bank #(.DB_W(DB_W)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_own   (set_self_v[c]),
                .clr_own   (clr_self_v[c]),
                .set_peer  (set_peer_v[PEER]),
                .clr_peer  (clr_peer_v[PEER]),
                .pend_q    (pend_v[c]),
                .pend_next (pend_nx_v[c])
            );

            db_irq_fsm #(.DB_W(DB_W)) u_fsm (
                .clk       (clk),
                .rst_n     (rst_n),
                .pend_next (pend_nx_v[c]),
                .irq       (irq_v[c])
            );

            db_read_mux #(.DATA_W(DATA_W), .DB_W(DB_W)) u_rd (
                .addr      (addr_v[c]),
                .own_pend  (pend_v[c]),
                .peer_pend (pend_v[PEER]),
                .rdata     (rdata_v[c])
            );
        end
    endgenerate

    assign c0_rdata = rdata_v[0];
    assign c1_rdata = rdata_v[1];
    assign irq0     = irq_v[0];
    assign irq1     = irq_v[1];
    assign pend_c0  = pend_v[0];
    assign pend_c1  = pend_v[1];

endmodule

// File: rtl/db_checker.sv
module db_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DB_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              c0_we,
    input logic [1:0]        c0_addr,
    input logic [DATA_W-1:0] c0_wdata,
    input logic              c1_we,
    input logic [1:0]        c1_addr,
    input logic [DATA_W-1:0] c1_wdata,
    input logic [DB_W-1:0]   pend0,
    input logic [DB_W-1:0]   pend1,
    input logic              irq0,
    input logic              irq1
);

    AST_RING_PEER_C0: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_we && c0_addr == 2'd0) |=> ((pend1 & $past(c0_wdata[DB_W-1:0])) == $past(c0_wdata[DB_W-1:0]))); // R1

    AST_WITHDRAW_PEER_C0: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_we && c0_addr == 2'd1 && !c1_we) |=> ((pend1 & $past(c0_wdata[DB_W-1:0])) == '0)); // R2

    AST_SET_SELF_C1: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_we && c1_addr == 2'd2) |=> ((pend1 & $past(c1_wdata[DB_W-1:0])) == $past(c1_wdata[DB_W-1:0]))); // R3

    AST_IRQ0_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq0 == (|pend0)); // R5

    AST_IRQ1_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq1 == (|pend1)); // R5

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (c0_we && c0_addr == 2'd2 && c1_we && c1_addr == 2'd1)
        |=> ((pend0 & $past(c0_wdata[DB_W-1:0])) == $past(c0_wdata[DB_W-1:0]))); // R7

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!c0_we && !c1_we) |=> ($stable(pend0) && $stable(pend1))); // R8

endmodule

bind doorbell_xcore db_checker #(.DATA_W(DATA_W), .DB_W(DB_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .c0_we    (c0_we),
    .c0_addr  (c0_addr),
    .c0_wdata (c0_wdata),
    .c1_we    (c1_we),
    .c1_addr  (c1_addr),
    .c1_wdata (c1_wdata),
    .pend0    (pend_c0),
    .pend1    (pend_c1),
    .irq0     (irq0),
    .irq1     (irq1)
);

// File: tb/doorbell_xcore_tb.sv
module doorbell_xcore_tb_top;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned DB_W   = 8;
    localparam int unsigned NVEC   = 13;

    typedef struct packed {
        logic [3:0]  rq;
        logic        we0;
        logic [1:0]  a0;
        logic [31:0] d0;
        logic        we1;
        logic [1:0]  a1;
        logic [31:0] d1;
        logic [7:0]  e0;
        logic [7:0]  e1;
    } vec_t;

    // Offsets: 0 ring peer, 1 withdraw peer, 2 set self, 3 acknowledge self
    localparam vec_t VEC [NVEC] = '{
        '{4'd1, 1'b1, 2'd0, 32'h05,       1'b0, 2'd0, 32'h0,  8'h00, 8'h05}, // R1
        '{4'd1, 1'b0, 2'd0, 32'h0,        1'b1, 2'd0, 32'h30, 8'h30, 8'h05}, // R1
        '{4'd3, 1'b1, 2'd2, 32'h03,       1'b0, 2'd0, 32'h0,  8'h33, 8'h05}, // R3
        '{4'd3, 1'b0, 2'd0, 32'h0,        1'b1, 2'd3, 32'h01, 8'h33, 8'h04}, // R3
        '{4'd2, 1'b1, 2'd1, 32'h04,       1'b0, 2'd0, 32'h0,  8'h33, 8'h00}, // R2
        '{4'd6, 1'b1, 2'd2, 32'hFFFFFF00, 1'b0, 2'd0, 32'h0,  8'h33, 8'h00}, // R6
        '{4'd7, 1'b1, 2'd0, 32'h80,       1'b1, 2'd3, 32'h80, 8'h33, 8'h80}, // R7
        '{4'd7, 1'b1, 2'd3, 32'h10,       1'b1, 2'd0, 32'h10, 8'h33, 8'h80}, // R7
        '{4'd8, 1'b1, 2'd0, 32'h02,       1'b1, 2'd0, 32'h40, 8'h73, 8'h82}, // R8
        '{4'd5, 1'b1, 2'd3, 32'h73,       1'b1, 2'd3, 32'h82, 8'h00, 8'h00}, // R5
        '{4'd3, 1'b0, 2'd0, 32'h0,        1'b1, 2'd2, 32'h08, 8'h00, 8'h08}, // R3
        '{4'd8, 1'b1, 2'd1, 32'h00,       1'b0, 2'd0, 32'h0,  8'h00, 8'h08}, // R8
        '{4'd6, 1'b1, 2'd2, 32'h100,      1'b0, 2'd0, 32'h0,  8'h00, 8'h08}  // R6
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              c0_we = 1'b0;
    logic [1:0]        c0_addr = 2'd0;
    logic [DATA_W-1:0] c0_wdata = '0;
    logic [DATA_W-1:0] c0_rdata;
    logic              c1_we = 1'b0;
    logic [1:0]        c1_addr = 2'd0;
    logic [DATA_W-1:0] c1_wdata = '0;
    logic [DATA_W-1:0] c1_rdata;
    logic              irq0;
    logic              irq1;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    doorbell_xcore #(.DATA_W(DATA_W), .DB_W(DB_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .c0_we    (c0_we),
        .c0_addr  (c0_addr),
        .c0_wdata (c0_wdata),
        .c0_rdata (c0_rdata),
        .c1_we    (c1_we),
        .c1_addr  (c1_addr),
        .c1_wdata (c1_wdata),
        .c1_rdata (c1_rdata),
        .irq0     (irq0),
        .irq1     (irq1)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input int idx);
        string tg;
        tg = $sformatf("R%0d vec%0d", v.rq, idx);
        @(negedge clk);
        c0_we = v.we0; c0_addr = v.a0; c0_wdata = v.d0;
        c1_we = v.we1; c1_addr = v.a1; c1_wdata = v.d1;
        @(negedge clk);
        c0_we = 1'b0; c1_we = 1'b0;
        c0_addr = 2'd2; c1_addr = 2'd2;
        #1;
        check({tg, " c0 own R4"}, c0_rdata, {24'h0, v.e0});
        check({tg, " c1 own R4"}, c1_rdata, {24'h0, v.e1});
        check({tg, " irq0 R5"}, {31'h0, irq0}, {31'h0, |v.e0});
        check({tg, " irq1 R5"}, {31'h0, irq1}, {31'h0, |v.e1});
        c0_addr = (idx % 2 == 0) ? 2'd0 : 2'd1;
        c1_addr = (idx % 2 == 0) ? 2'd1 : 2'd0;
        #1;
        check({tg, " c0 peer R4"}, c0_rdata, {24'h0, v.e1});
        check({tg, " c1 peer R4"}, c1_rdata, {24'h0, v.e0});
        c1_addr = 2'd3;
        #1;
        check({tg, " c1 ack-offset read R4"}, c1_rdata, {24'h0, v.e1});
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset state, R9
        #5;
        check("R9 irq0 in reset", {31'h0, irq0}, 32'h0);
        check("R9 irq1 in reset", {31'h0, irq1}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            c0_addr = 2'(a); c1_addr = 2'(a);
            #1;
            check("R9 c0 read after reset", c0_rdata, 32'h0);
            check("R9 c1 read after reset", c1_rdata, 32'h0);
        end

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i], i);
        end

        // R4: write not visible before its edge, visible after it
        @(negedge clk);
        c0_we = 1'b1; c0_addr = 2'd0; c0_wdata = 32'h01;
        #1;
        check("R4 read before edge", c0_rdata, 32'h08);
        @(negedge clk);
        c0_we = 1'b0;
        #1;
        check("R4 read after edge", c0_rdata, 32'h09);
        check("R5 irq0 stays low", {31'h0, irq0}, 32'h0);

        // R9: reset mid-run clears everything
        rst_n = 1'b0;
        #1;
        check("R9 irq1 after mid-run reset", {31'h0, irq1}, 32'h0);
        c1_addr = 2'd2;
        #1;
        check("R9 c1 own after mid-run reset", c1_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 c0 peer after reset release", c0_rdata, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule